// File: doc/BRIEF.md
# Chainable Doubleword Left Shifter

This execute-stage unit shifts a 64-bit data word left by a count taken from a second operand. The low bit positions that the shift empties are filled from a third operand, the fill word. The bits that leave the top of the data word are not discarded. They come back as a second result, right-aligned. A flag reports whether any nonzero bit was lost this way. When an operation's record bit is set, the unit also writes a small condition field with that loss flag and a zero flag for the main result.

Wider values can be shifted as a chain of 64-bit words. Start at the least significant word. Pass each word's spill result in as the fill word of the next word, using the same count each time. The spill of the top word holds the bits that leave the whole multi-word value.

The unit takes one operation per cycle on a valid-in strobe. It returns the results through one register stage, with a valid-out strobe.

Top module: `dword_shl_unit`

## Requirements
- R1: The shift count n is the low 6 bits of `amountOp`, in the range 0 to 63. Bits 63:6 of `amountOp` have no effect on any output.
- R2: `shiftResult` bits 63:n equal `dataOp` bits 63-n:0. Bits n-1:0 equal `fillOp` bits n-1:0, taken without any shift.
- R3: `spillResult` bits n-1:0 equal `dataOp` bits 63:64-n. All higher bits of `spillResult` are zero.
- R4: When n is 0, `shiftResult` equals `dataOp`, `spillResult` is zero and `overflowFlag` is low.
- R5: `overflowFlag` is high exactly when `spillResult` is nonzero.
- R6: `outValid` is high in the cycle after a cycle with `inValid` high, and low otherwise. The results of an operation appear together with that `outValid`.
- R7: `condWrite` is high in the cycle after an operation that was accepted with `recordBit` high, and low at all other times.
- R8: While `condWrite` is high, `condOverflow` equals `overflowFlag` and `condZero` is high exactly when `shiftResult` is zero. While `condWrite` is low, both `condOverflow` and `condZero` are low.
- R9: Four chained operations compute the left shift of a 256-bit value by n. Each operation uses the same count, and each word's fill is the previous word's spill, with a zero fill for the lowest word.
- R10: A synchronous active-high `rst` clears `outValid`, both results and all flags on the next clock edge.
- R11: In a cycle with `inValid` low, the results and flags keep their values, whatever the operand inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | The operands carry an operation this cycle |
| dataOp | input | 64 | Word to be shifted |
| amountOp | input | 64 | Shift amount; only bits 5:0 are used |
| fillOp | input | 64 | Supplies the vacated low bits |
| recordBit | input | 1 | Request a condition-field update |
| outValid | output | 1 | The results are from a new operation |
| shiftResult | output | 64 | Shifted word with its low bits filled |
| spillResult | output | 64 | Bits shifted out of the top, right-aligned |
| overflowFlag | output | 1 | A nonzero bit was shifted out |
| condWrite | output | 1 | Condition-field write enable |
| condOverflow | output | 1 | Condition-field loss flag |
| condZero | output | 1 | Condition-field zero flag |

## Verification
The embedded assertions watch several relations on every cycle:
- the one-cycle valid latency;
- the link between the spill result and the loss flag;
- the gating of the condition field by the record bit;
- the zero-count passthrough;
- the holding of results between operations;
- the reset clearing.

The exact bit placement of the shifted, filled and spilled bits needs known operand values. So do the disregard of the upper amount bits and the correctness of a multi-word chain. Only the bench's scenarios show these. They sweep every count from 0 to 63 and compare the results with a per-bit model. They also check a four-word chain against a 256-bit shift.

// File: rtl/shl_pkg.sv
package shl_pkg;
  typedef struct packed {
    logic capture;
    logic record;
  } shlStrobes_t;
endpackage

// File: rtl/shl_control.sv
module shl_control
  import shl_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  input  logic        recordBit,
  output shlStrobes_t strobes,
  output logic        outValid,
  output logic        condWrite
);
  assign strobes.capture = inValid;
  assign strobes.record  = inValid & recordBit;

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid  <= 1'b0;
      condWrite <= 1'b0;
    end else begin
      outValid  <= inValid;
      condWrite <= inValid & recordBit;
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst) inValid |=> outValid); // R6
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst) !inValid |=> !outValid); // R6
  AST_COND_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst) condWrite |-> outValid); // R7
  AST_NO_RECORD: assert property (@(posedge clk) disable iff (rst) !recordBit |=> !condWrite); // R7
endmodule

// File: rtl/shl_datapath.sv
module shl_datapath
  import shl_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  shlStrobes_t       strobes,
  input  logic [DATA_W-1:0] dataOp,
  input  logic [DATA_W-1:0] amountOp,
  input  logic [DATA_W-1:0] fillOp,
  output logic [DATA_W-1:0] shiftResult,
  output logic [DATA_W-1:0] spillResult,
  output logic              overflowFlag,
  output logic              condOverflow,
  output logic              condZero
);
  localparam int CNT_W = $clog2(DATA_W);

  logic [CNT_W-1:0]    shiftCnt;
  logic [2*DATA_W-1:0] doubled;
  logic [DATA_W-1:0]   rotated;
  logic [DATA_W-1:0]   keepMask;
  logic [DATA_W-1:0]   nextShift;
  logic [DATA_W-1:0]   nextSpill;
  logic                nextOvf;

  always_comb begin
    shiftCnt  = amountOp[CNT_W-1:0];
    doubled   = {dataOp, dataOp} << shiftCnt;
    rotated   = doubled[2*DATA_W-1:DATA_W];
    keepMask  = {DATA_W{1'b1}} << shiftCnt;
    nextShift = (rotated & keepMask) | (fillOp & ~keepMask);
    nextSpill = rotated & ~keepMask;
    nextOvf   = |nextSpill;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftResult  <= '0;
      spillResult  <= '0;
      overflowFlag <= 1'b0;
      condOverflow <= 1'b0;
      condZero     <= 1'b0;
    end else begin
      if (strobes.capture) begin
        shiftResult  <= nextShift;
        spillResult  <= nextSpill;
        overflowFlag <= nextOvf;
      end
      condOverflow <= strobes.record & nextOvf;
      condZero     <= strobes.record & (nextShift == '0);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) (spillResult == '0) |-> !overflowFlag); // R5
  AST_OVERFLOW_SET: assert property (@(posedge clk) disable iff (rst) (spillResult != '0) |-> overflowFlag); // R5
  AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (rst)
    (strobes.capture && amountOp[CNT_W-1:0] == '0) |=> (shiftResult == $past(dataOp) && spillResult == '0)); // R4
  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strobes.capture |=> ($stable(shiftResult) && $stable(spillResult) && $stable(overflowFlag))); // R11
  AST_COND_OVF: assert property (@(posedge clk) disable iff (rst) condOverflow |-> overflowFlag); // R8
  AST_COND_ZERO: assert property (@(posedge clk) disable iff (rst) condZero |-> (shiftResult == '0)); // R8
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (shiftResult == '0 && spillResult == '0 && !overflowFlag && !condZero)); // R10
endmodule

// File: rtl/dword_shl_unit.sv
module dword_shl_unit
  import shl_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [DATA_W-1:0] dataOp,
  input  logic [DATA_W-1:0] amountOp,
  input  logic [DATA_W-1:0] fillOp,
  input  logic              recordBit,
  output logic              outValid,
  output logic [DATA_W-1:0] shiftResult,
  output logic [DATA_W-1:0] spillResult,
  output logic              overflowFlag,
  output logic              condWrite,
  output logic              condOverflow,
  output logic              condZero
);
  shlStrobes_t strobes;

  shl_control ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .inValid   (inValid),
    .recordBit (recordBit),
    .strobes   (strobes),
    .outValid  (outValid),
    .condWrite (condWrite)
  );

  shl_datapath #(.DATA_W(DATA_W)) dp_i (
    .clk          (clk),
    .rst          (rst),
    .strobes      (strobes),
    .dataOp       (dataOp),
    .amountOp     (amountOp),
    .fillOp       (fillOp),
    .shiftResult  (shiftResult),
    .spillResult  (spillResult),
    .overflowFlag (overflowFlag),
    .condOverflow (condOverflow),
    .condZero     (condZero)
  );

  AST_COND_MATCH: assert property (@(posedge clk) disable iff (rst) condWrite |-> (condOverflow == overflowFlag)); // R8
  AST_COND_QUIET: assert property (@(posedge clk) disable iff (rst) !condWrite |-> (!condOverflow && !condZero)); // R8
endmodule

// File: tb/dword_shl_unit_tb.sv
module dword_shl_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [63:0] dataOp = '0;
  logic [63:0] amountOp = '0;
  logic [63:0] fillOp = '0;
  logic        recordBit = 1'b0;
  logic        outValid;
  logic [63:0] shiftResult;
  logic [63:0] spillResult;
  logic        overflowFlag;
  logic        condWrite;
  logic        condOverflow;
  logic        condZero;

  int checkCnt = 0;
  int failCnt = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dword_shl_unit dut_i (
    .clk(clk), .rst(rst), .inValid(inValid), .dataOp(dataOp), .amountOp(amountOp),
    .fillOp(fillOp), .recordBit(recordBit), .outValid(outValid), .shiftResult(shiftResult),
    .spillResult(spillResult), .overflowFlag(overflowFlag), .condWrite(condWrite),
    .condOverflow(condOverflow), .condZero(condZero)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Per-bit model of the requirement text (R2, R3)
  function automatic logic [63:0] refShift(input logic [63:0] d, input logic [63:0] f, input int n);
    logic [63:0] r;
    for (int i = 0; i < 64; i++) r[i] = (i >= n) ? d[i-n] : f[i];
    return r;
  endfunction

  function automatic logic [63:0] refSpill(input logic [63:0] d, input int n);
    logic [63:0] r;
    for (int i = 0; i < 64; i++) r[i] = (i < n) ? d[64-n+i] : 1'b0;
    return r;
  endfunction

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  // One operation; sampled on the falling edge after the capturing edge
  task automatic runOp(input logic [63:0] d, input logic [63:0] a, input logic [63:0] f, input logic rec);
    @(negedge clk);
    inValid = 1'b1; dataOp = d; amountOp = a; fillOp = f; recordBit = rec;
    @(negedge clk);
    inValid = 1'b0; recordBit = 1'b0;
  endtask

  task automatic checkOp(input string req, input logic [63:0] d, input logic [63:0] a,
                         input logic [63:0] f, input logic rec);
    int n;
    logic [63:0] es, ep;
    n = int'(a[5:0]);
    runOp(d, a, f, rec);
    es = refShift(d, f, n);
    ep = refSpill(d, n);
    chk({req, " R2 shift"}, shiftResult, es);
    chk({req, " R3 spill"}, spillResult, ep);
    chk({req, " R5 ovf"}, 64'(overflowFlag), 64'(ep != 0));
    chk({req, " R6 valid"}, 64'(outValid), 64'd1);
    chk({req, " R7 write"}, 64'(condWrite), 64'(rec));
    chk({req, " R8 cOvf"}, 64'(condOverflow), 64'(rec && ep != 0));
    chk({req, " R8 cZero"}, 64'(condZero), 64'(rec && es == 0));
  endtask

  task automatic testReset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 valid", 64'(outValid), 64'd0);
    chk("R10 shift", shiftResult, 64'd0);
    chk("R10 spill", spillResult, 64'd0);
    chk("R10 flags", {61'd0, overflowFlag, condWrite, condZero}, 64'd0);
    rst = 1'b0;
  endtask

  task automatic testAllCounts();
    for (int n = 0; n < 64; n++)
      checkOp("sweep", rnd64(), 64'(n), rnd64(), n[0]);
  endtask

  task automatic testZeroCount();
    runOp(64'hF00D_1234_5678_9ABC, 64'd0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
    chk("R4 pass", shiftResult, 64'hF00D_1234_5678_9ABC);
    chk("R4 spill", spillResult, 64'd0);
    chk("R4 ovf", 64'(overflowFlag), 64'd0);
  endtask

  task automatic testUpperIgnored();
    logic [63:0] d, f, s1, p1;
    d = rnd64(); f = rnd64();
    runOp(d, 64'd13, f, 1'b0);
    s1 = shiftResult; p1 = spillResult;
    runOp(d, 64'hABCD_0000_0000_0F40 | 64'd13, f, 1'b0);
    chk("R1 shift", shiftResult, s1);
    chk("R1 spill", spillResult, p1);
    runOp(d, 64'hFFFF_FFFF_FFFF_FFC0, f, 1'b0);
    chk("R1 high-only", shiftResult, d);
  endtask

  task automatic testRandom();
    for (int i = 0; i < 40; i++)
      checkOp("random", rnd64(), rnd64(), rnd64(), 1'($urandom()));
  endtask

  task automatic testCond();
    checkOp("R8 zero", 64'h8000_0000_0000_0000, 64'd1, 64'd0, 1'b1);
    chk("R8 zero set", 64'(condZero), 64'd1);
    checkOp("R7 off", 64'hFFFF_0000_0000_0000, 64'd8, 64'd0, 1'b0);
    chk("R7 off flag", 64'(overflowFlag), 64'd1);
  endtask

  task automatic testHold();
    logic [63:0] s1, p1;
    checkOp("hold", 64'h0123_4567_89AB_CDEF, 64'd20, 64'h5555_5555_5555_5555, 1'b0);
    s1 = shiftResult; p1 = spillResult;
    dataOp = '1; amountOp = 64'd5; fillOp = '1;
    repeat (3) @(negedge clk);
    chk("R11 shift", shiftResult, s1);
    chk("R11 spill", spillResult, p1);
    chk("R6 idle", 64'(outValid), 64'd0);
  endtask

  task automatic testChain(input int n);
    logic [255:0] big, expd;
    logic [63:0] carry, outTop;
    big = {rnd64(), rnd64(), rnd64(), rnd64()};
    expd = big << n;
    carry = '0;
    for (int w = 0; w < 4; w++) begin
      runOp(big[w*64 +: 64], 64'(n), carry, 1'b0);
      chk("R9 word", shiftResult, expd[w*64 +: 64]);
      carry = spillResult;
    end
    outTop = refSpill(big[255:192], n);
    chk("R9 top spill", carry, outTop);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
      $finish;
    end
  end

  initial begin
    testReset();
    testZeroCount();
    testAllCounts();
    testUpperIgnored();
    testRandom();
    testCond();
    testHold();
    testChain(0);
    testChain(1);
    testChain(37);
    testChain(63);
    runOp(64'hFFFF_FFFF_FFFF_FFFF, 64'd4, 64'd0, 1'b1);
    testReset();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
    $finish;
  end
endmodule